// File: doc/BRIEF.md
# Prioritized Interrupt Selector

This block decides, once per clock, whether the hart should take an interrupt and which one. It receives the vector of pending interrupt lines, the mask that hands individual lines down to supervisor level, the current privilege level, the global interrupt enables of machine and supervisor mode, and the cause field of the debug state. From these it produces a registered take strobe and a cause word. The cause word has its top bit set and carries the chosen line's index in its low bits.

Selection runs in two stages. The first stage works by privilege level. Lines that stay at machine level are considered first. They are gated by the machine enable rule. Delegated lines are looked at only when no machine-level line survives that gate. The second stage works by interrupt class within the surviving set. Custom lines above bit 11 come first, then the external lines, then the software lines, then the timer lines. Among the lines that survive the class filter, the lowest index wins.

The surrounding core samples `take_o` and `cause_o` to start trap entry. Trap entry itself, the pending and enable registers, and the pipeline all live outside this block.

Top module: `irq_select_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `take_o` is 0 and `cause_o` is all zeros.
- R2: A pending line whose mask bit is 0 is a machine candidate when `priv_i` is 0 (user) or 1 (supervisor). When `priv_i` is 3 (machine), it is a candidate only if `m_gie_i` is 1. With `priv_i` = 3 and `m_gie_i` = 0, such lines are never taken.
- R3: When at least one machine candidate exists, delegated lines (mask bit 1) are ignored, even if they belong to a higher-priority class.
- R4: Delegated pending lines are taken only when no machine candidate exists and supervisor interrupts are enabled. They are enabled when `priv_i` is 0, or when `priv_i` is 1 and `s_gie_i` is 1. With `priv_i` = 3 they are never taken.
- R5: While `dbg_cause_i` is nonzero, no interrupt is taken.
- R6: Within the candidate set, the class order from highest to lowest is: bits 12 and above, then bits 9 and 11, then bits 1 and 3, then bits 5 and 7. Candidates only at bits 0, 2, 4, 6, 8 or 10 cause no take.
- R7: Within the winning class, the line with the lowest index is chosen. For example, 9 is chosen over 11, 1 over 3, 5 over 7, and 13 over 20.
- R8: When taken, `cause_o` has bit XLEN-1 set and the chosen index in its low $clog2(XLEN) bits. All other bits are 0.
- R9: Outputs are registered. They reflect the inputs that were present at the previous rising clock edge.
- R10: When no line is taken, `take_o` is 0 and `cause_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | XLEN | Pending interrupt lines |
| deleg_i | input | XLEN | Delegation mask, 1 = handed to supervisor level |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| dbg_cause_i | input | DBG_W | Debug cause, nonzero while in debug mode |
| take_o | output | 1 | Take-interrupt strobe |
| cause_o | output | XLEN | Interrupt cause word |

## Verification
The hardest case sets up machine-level lines that are pending but blocked by a clear machine enable while running in machine mode, together with delegated lines that are pending. In that case selection must fall through to the supervisor stage, and the supervisor rule must then refuse the take as well. The stimulus reaches this case by holding the same pending mix and stepping privilege and enables through machine, supervisor and user. It also mixes classes across the two levels, so that a low-class machine line competes with a high-class delegated line. Every vector is queued with its expected strobe and cause. The held cause value is tracked across cycles in which nothing is taken.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // interrupt line positions whose class the selector decodes
  localparam int unsigned BIT_SW_S   = 1;
  localparam int unsigned BIT_SW_M   = 3;
  localparam int unsigned BIT_TMR_S  = 5;
  localparam int unsigned BIT_TMR_M  = 7;
  localparam int unsigned BIT_EXT_S  = 9;
  localparam int unsigned BIT_EXT_M  = 11;
  localparam int unsigned BIT_CUST_LO = BIT_EXT_M + 1;

endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_sel_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] deleg_i,
  input  logic [1:0]   priv_i,
  input  logic         m_gie_i,
  input  logic         s_gie_i,
  output logic [W-1:0] cand_o
);

  priv_e       priv;
  logic        m_en;
  logic        s_en;
  logic [W-1:0] m_set;
  logic [W-1:0] s_set;

  always_comb begin
    priv = priv_e'(priv_i);
    m_en = (priv != PRIV_MACH) || m_gie_i;
    s_en = (priv == PRIV_USER) || ((priv == PRIV_SUPER) && s_gie_i);
    m_set = pend_i & ~deleg_i & {W{m_en}};
    s_set = pend_i &  deleg_i & {W{s_en}};
    cand_o = (|m_set) ? m_set : s_set;
  end

endmodule

// File: rtl/irq_class_filter.sv
module irq_class_filter
  import irq_sel_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] cand_i,
  output logic [W-1:0] kept_o
);

  logic [W-1:0] msk_cust;
  logic [W-1:0] msk_ext;
  logic [W-1:0] msk_sw;
  logic [W-1:0] msk_tmr;

  for (genvar b = 0; b < W; b++) begin : g_mask
    assign msk_cust[b] = (b >= BIT_CUST_LO);
    assign msk_ext[b]  = (b == BIT_EXT_S) || (b == BIT_EXT_M);
    assign msk_sw[b]   = (b == BIT_SW_S)  || (b == BIT_SW_M);
    assign msk_tmr[b]  = (b == BIT_TMR_S) || (b == BIT_TMR_M);
  end

  always_comb begin
    if (|(cand_i & msk_cust))      kept_o = cand_i & msk_cust;
    else if (|(cand_i & msk_ext))  kept_o = cand_i & msk_ext;
    else if (|(cand_i & msk_sw))   kept_o = cand_i & msk_sw;
    else if (|(cand_i & msk_tmr))  kept_o = cand_i & msk_tmr;
    else                           kept_o = '0;
  end

endmodule

// File: rtl/irq_lsb_index.sv
module irq_lsb_index #(
  parameter int unsigned W  = 64,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);

  always_comb begin
    idx_o   = '0;
    valid_o = |vec_i;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/irq_select_top.sv
module irq_select_top #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned DBG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   pend_i,
  input  logic [XLEN-1:0]   deleg_i,
  input  logic [1:0]        priv_i,
  input  logic              m_gie_i,
  input  logic              s_gie_i,
  input  logic [DBG_W-1:0]  dbg_cause_i,
  output logic              take_o,
  output logic [XLEN-1:0]   cause_o
);

  localparam int unsigned IW  = $clog2(XLEN);
  localparam int unsigned PAD = XLEN - 1 - IW;

  logic [XLEN-1:0] cand;
  logic [XLEN-1:0] kept;
  logic [IW-1:0]   win_idx;
  logic            win_vld;
  logic            take_nxt;
  logic [XLEN-1:0] cause_nxt;
  logic            cause_en;
  logic            take_q;
  logic [XLEN-1:0] cause_q;

  irq_level_gate #(.W(XLEN)) u_level (
    .pend_i  (pend_i),
    .deleg_i (deleg_i),
    .priv_i  (priv_i),
    .m_gie_i (m_gie_i),
    .s_gie_i (s_gie_i),
    .cand_o  (cand)
  );

  irq_class_filter #(.W(XLEN)) u_class (
    .cand_i (cand),
    .kept_o (kept)
  );

  irq_lsb_index #(.W(XLEN), .IW(IW)) u_index (
    .vec_i   (kept),
    .idx_o   (win_idx),
    .valid_o (win_vld)
  );

  // next-state
  always_comb begin
    take_nxt  = win_vld && (dbg_cause_i == '0);
    cause_en  = take_nxt;
    cause_nxt = {1'b1, {PAD{1'b0}}, win_idx};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
    end else begin
      take_q <= take_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (cause_en) begin
      cause_q <= cause_nxt;
    end
  end

  assign take_o  = take_q;
  assign cause_o = cause_q;

endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned DBG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   pend_i,
  input  logic [XLEN-1:0]   deleg_i,
  input  logic [1:0]        priv_i,
  input  logic              m_gie_i,
  input  logic              s_gie_i,
  input  logic [DBG_W-1:0]  dbg_cause_i,
  input  logic              take_o,
  input  logic [XLEN-1:0]   cause_o
);

  localparam int unsigned IW = $clog2(XLEN);

  logic [XLEN-1:0] pend_q;
  logic [XLEN-1:0] deleg_q;
  logic [1:0]      priv_q;
  logic            mgie_q;
  logic            sgie_q;
  logic [IW-1:0]   idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      deleg_q <= '0;
      priv_q  <= '0;
      mgie_q  <= 1'b0;
      sgie_q  <= 1'b0;
    end else begin
      pend_q  <= pend_i;
      deleg_q <= deleg_i;
      priv_q  <= priv_i;
      mgie_q  <= m_gie_i;
      sgie_q  <= s_gie_i;
    end
  end

  assign idx = cause_o[IW-1:0];

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !take_o); // R1

  AST_MACH_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !deleg_q[idx]) |-> ((priv_q != 2'd3) || mgie_q)); // R2

  AST_SUP_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && deleg_q[idx]) |-> ((priv_q == 2'd0) || ((priv_q == 2'd1) && sgie_q))); // R4

  AST_DEBUG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_cause_i != '0) |=> !take_o); // R5

  AST_CAUSE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (cause_o[XLEN-1] && (cause_o[XLEN-2:IW] == '0))); // R8

  AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> pend_q[idx]); // R9

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> $stable(cause_o)); // R10

endmodule

bind irq_select_top irq_select_chk #(.XLEN(XLEN), .DBG_W(DBG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pend_i      (pend_i),
  .deleg_i     (deleg_i),
  .priv_i      (priv_i),
  .m_gie_i     (m_gie_i),
  .s_gie_i     (s_gie_i),
  .dbg_cause_i (dbg_cause_i),
  .take_o      (take_o),
  .cause_o     (cause_o)
);

// File: tb/tb_irq_select_top.sv
module tb_irq_select_top;

  localparam int unsigned XLEN  = 64;
  localparam int unsigned DBG_W = 3;
  localparam logic [XLEN-1:0] MARK = {1'b1, {(XLEN-1){1'b0}}};

  typedef struct {
    logic            take;
    logic [XLEN-1:0] cause;
    string           tag;
  } exp_t;

  logic              clk;
  logic              rst_n;
  logic [XLEN-1:0]   pend_i;
  logic [XLEN-1:0]   deleg_i;
  logic [1:0]        priv_i;
  logic              m_gie_i;
  logic              s_gie_i;
  logic [DBG_W-1:0]  dbg_cause_i;
  logic              take_o;
  logic [XLEN-1:0]   cause_o;

  int total = 0;
  int bad   = 0;
  logic [XLEN-1:0] held_cause = '0;
  exp_t sbq[$];
  bit   finished = 0;

  irq_select_top #(.XLEN(XLEN), .DBG_W(DBG_W)) dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .deleg_i(deleg_i),
    .priv_i(priv_i), .m_gie_i(m_gie_i), .s_gie_i(s_gie_i),
    .dbg_cause_i(dbg_cause_i), .take_o(take_o), .cause_o(cause_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [XLEN-1:0] bits(input int a, input int b = -1, input int c = -1,
                                           input int d = -1, input int e = -1);
    logic [XLEN-1:0] v = '0;
    if (a >= 0) v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    if (d >= 0) v[d] = 1'b1;
    if (e >= 0) v[e] = 1'b1;
    return v;
  endfunction

  task automatic drive(input logic [XLEN-1:0] p, input logic [XLEN-1:0] d,
                       input logic [1:0] pr, input logic me, input logic se,
                       input logic [DBG_W-1:0] dc, input logic et, input int ei,
                       input string tag);
    exp_t it;
    @(negedge clk);
    pend_i = p; deleg_i = d; priv_i = pr; m_gie_i = me; s_gie_i = se; dbg_cause_i = dc;
    if (et) held_cause = MARK | XLEN'(ei);
    it.take = et; it.cause = held_cause; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: one scoreboard item per rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t it;
        it = sbq.pop_front();
        total++;
        if (take_o !== it.take || cause_o !== it.cause) begin
          bad++;
          $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
                   it.tag, take_o, cause_o, it.take, it.cause);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pend_i = bits(7); deleg_i = '0; priv_i = 2'd3; m_gie_i = 1'b1; s_gie_i = 1'b1;
    dbg_cause_i = '0;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (take_o !== 1'b0 || cause_o !== '0) begin
      bad++;
      $display("FAIL R1 during reset: take=%0b cause=%h expected take=0 cause=0", take_o, cause_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    total++;
    if (take_o !== 1'b0 || cause_o !== '0) begin
      bad++;
      $display("FAIL R1 after release: take=%0b cause=%h expected take=0 cause=0", take_o, cause_o);
    end

    // machine enable
    drive(bits(7), '0, 2'd3, 1'b1, 1'b0, '0, 1'b1, 7,  "R2 M-mode mie=1 timer");
    drive(bits(7), '0, 2'd3, 1'b0, 1'b0, '0, 1'b0, 0,  "R2 R10 M-mode mie=0 blocked, cause held");
    drive(bits(7), '0, 2'd0, 1'b0, 1'b0, '0, 1'b1, 7,  "R2 U-mode ignores mie");
    drive(bits(3), '0, 2'd1, 1'b0, 1'b0, '0, 1'b1, 3,  "R2 R9 S-mode machine software");
    // level ordering
    drive(bits(7, 9), bits(9), 2'd1, 1'b0, 1'b1, '0, 1'b1, 7, "R3 machine timer beats delegated external");
    drive(bits(7, 9), bits(9), 2'd3, 1'b0, 1'b1, '0, 1'b0, 0, "R4 M-mode masked, delegated not taken");
    drive(bits(9), bits(9), 2'd1, 1'b0, 1'b1, '0, 1'b1, 9, "R4 S-mode sie=1 delegated");
    drive(bits(9), bits(9), 2'd1, 1'b1, 1'b0, '0, 1'b0, 0, "R4 R10 S-mode sie=0 held");
    drive(bits(9), bits(9), 2'd0, 1'b0, 1'b0, '0, 1'b1, 9, "R4 U-mode delegated");
    drive(bits(7, 9), bits(9), 2'd3, 1'b1, 1'b1, '0, 1'b1, 7, "R3 R2 M-mode mie=1 machine only");
    // debug
    drive(bits(11), '0, 2'd0, 1'b1, 1'b1, 3'd1, 1'b0, 0, "R5 debug cause 1");
    drive(bits(11), '0, 2'd0, 1'b1, 1'b1, 3'd4, 1'b0, 0, "R5 debug cause 4");
    drive(bits(11), '0, 2'd0, 1'b1, 1'b1, 3'd0, 1'b1, 11, "R5 R9 debug left");
    // class ordering
    drive(bits(16, 11, 3, 7), '0, 2'd0, 1'b0, 1'b0, '0, 1'b1, 16, "R6 custom first");
    drive(bits(11, 3, 7), '0, 2'd0, 1'b0, 1'b0, '0, 1'b1, 11, "R6 external next");
    drive(bits(3, 7, 1), '0, 2'd0, 1'b0, 1'b0, '0, 1'b1, 1, "R6 R7 software next, lowest");
    drive(bits(5, 7), '0, 2'd0, 1'b0, 1'b0, '0, 1'b1, 5, "R7 timer lowest");
    drive(bits(11, 9), '0, 2'd0, 1'b0, 1'b0, '0, 1'b1, 9, "R7 external lowest");
    drive(bits(0, 2, 4, 8, 10), '0, 2'd0, 1'b0, 1'b0, '0, 1'b0, 0, "R6 R10 unclassed lines");
    drive(bits(20, 13, 6), '0, 2'd0, 1'b0, 1'b0, '0, 1'b1, 13, "R7 custom lowest");
    drive(bits(63), '0, 2'd1, 1'b0, 1'b0, '0, 1'b1, 63, "R8 top line cause word");
    drive(bits(5), bits(5), 2'd1, 1'b0, 1'b1, '0, 1'b1, 5, "R8 R9 delegated timer");
    drive('0, '0, 2'd0, 1'b1, 1'b1, '0, 1'b0, 0, "R10 nothing pending");

    repeat (3) @(posedge clk);
    #1;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule